// File: doc/BRIEF.md
# Euler-Step Recurrence Datapath

This block integrates a second-order differential equation with forward Euler steps. A start pulse captures five signed Q16.16 operands: a position `x`, a solution value `y`, a derivative `u`, a step size `dx` and a bound `a`. The block then repeats one update of `x`, `u` and `y` until the stop condition holds. It then returns the final `y` with a single-cycle done pulse.

Each iteration needs four products and six add, subtract or compare operations. These run on a small pool of multipliers and ALUs under a fixed per-step schedule. Two parameters choose one or two multipliers and one or two ALUs, which trades cycles per iteration against area. Arithmetic wraps modulo 2^32. The factor of three is formed as a doubling plus an add on an ALU, so no multiplier is used for it.

Top module: `euler_diffeq_dp`

## Requirements
- R1: While idle, a high `start` captures `x_in`, `y_in`, `u_in`, `dx_in` and `a_in` at the clock edge, and `busy` is high from the next cycle.
- R2: Each iteration replaces x with x + dx, using 32-bit wrapping addition.
- R3: A product P(p,q) is bits 47:16 of the signed 64-bit product p·q. Each iteration replaces u with u − 3·(P(P(x,u),dx) + P(y,dx)), using wrapping arithmetic and the x, u and y from the start of the iteration.
- R4: Each iteration replaces y with y + P(u,dx), using the u from before the update. x, u and y are committed together at the same edge.
- R5: The loop runs at least once. After each iteration it runs again only if the pre-update x was less than a (signed comparison); otherwise `busy` falls.
- R6: `done` is high for exactly one cycle when the loop ends. `y_out` then shows the final y and holds it until the next accepted start.
- R7: A `start` pulse while `busy` is high has no effect on the timing or the result of the running problem.
- R8: One iteration takes 8, 7, 7 or 6 cycles for (multipliers, ALUs) = (1,1), (1,2), (2,1) or (2,2). With N iterations, `done` is high in the cycle after the N·P-th edge that follows the start edge.
- R9: After reset, `busy`, `done` and `y_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new problem when idle |
| x_in | input | 32 | Initial x, Q16.16 |
| y_in | input | 32 | Initial y, Q16.16 |
| u_in | input | 32 | Initial u, Q16.16 |
| dx_in | input | 32 | Step size, Q16.16 |
| a_in | input | 32 | Bound on x, Q16.16 |
| busy | output | 1 | Problem in progress |
| done | output | 1 | One-cycle end pulse |
| y_out | output | 32 | Final y, Q16.16 |

## Verification
The bench counts clock edges from the edge that accepts `start`. `busy` is due high one cycle after that edge. `done` is due exactly N·P edges later, where N comes from a wrapping fixed-point model of the recurrence and P is the per-iteration cycle count of each instance. The four resource configurations run side by side on the same stimulus. At every falling edge the bench compares each instance's `busy` and `done` with the value its own count predicts. It checks `y_out` in the done cycle and again after the pulse has gone. A second start is driven into the middle of a run, and the bench confirms that the done cycle and the result do not move.

// File: rtl/euler_diffeq_dp.sv
`timescale 1ns/1ps
module euler_diffeq_dp #(
  parameter int W    = 32,
  parameter int FRAC = 16,
  parameter int NMUL = 1,
  parameter int NALU = 1
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic signed [W-1:0] x_in,
  input  logic signed [W-1:0] y_in,
  input  logic signed [W-1:0] u_in,
  input  logic signed [W-1:0] dx_in,
  input  logic signed [W-1:0] a_in,
  output logic                busy,
  output logic                done,
  output logic signed [W-1:0] y_out
);
  localparam int CFG   = (NMUL == 2 ? 2 : 0) + (NALU == 2 ? 1 : 0);
  localparam int CSTEP = (CFG == 0) ? 7 : (CFG == 3) ? 5 : 6;
  localparam int SW    = $clog2(CSTEP + 1);

  // op codes: multiplier 1..4 = xu, xu*dx, y*dx, u*dx
  // alu 1 x+dx, 2 x<a, 3 sum of products, 4 triple, 5 u-t, 6 y+ud
  function automatic logic [23:0] mul_word(input int k);
    if (NMUL == 2) return (k == 0) ? 24'o00000021 : 24'o00000043;
    return 24'o00004321;
  endfunction

  function automatic logic [23:0] alu_word(input int k);
    case (CFG)
      0:       return (k == 0) ? 24'o06543021 : 24'o0;
      1:       return (k == 0) ? 24'o00543001 : 24'o00060002;
      2:       return (k == 0) ? 24'o00654321 : 24'o0;
      default: return (k == 0) ? 24'o00054301 : 24'o00000602;
    endcase
  endfunction

  logic [SW-1:0] step;
  logic signed [W-1:0] x_r, y_r, u_r, dx_r, a_r;
  logic signed [W-1:0] p1, p2, p3, p4, xn, sm, tr, un, yn;
  logic cf;

  logic [2:0]          mop [NMUL];
  logic signed [W-1:0] mr  [NMUL];
  logic [2:0]          aop [NALU];
  logic signed [W-1:0] ar  [NALU];

  wire run = busy && (step != SW'(CSTEP));

  for (genvar g = 0; g < NMUL; g++) begin : g_mul
    localparam logic [23:0] MW = mul_word(g);
    logic signed [W-1:0]   ma, mb;
    logic signed [2*W-1:0] p;
    assign mop[g] = MW[3*step +: 3];
    always_comb begin
      case (mop[g])
        3'd2:    begin ma = p1;  mb = dx_r; end
        3'd3:    begin ma = y_r; mb = dx_r; end
        3'd4:    begin ma = u_r; mb = dx_r; end
        default: begin ma = x_r; mb = u_r;  end
      endcase
    end
    assign p      = {{W{ma[W-1]}}, ma} * {{W{mb[W-1]}}, mb};
    assign mr[g]  = W'(p >>> FRAC);
  end

  for (genvar g = 0; g < NALU; g++) begin : g_alu
    localparam logic [23:0] AW = alu_word(g);
    assign aop[g] = AW[3*step +: 3];
    always_comb begin
      case (aop[g])
        3'd1:    ar[g] = x_r + dx_r;
        3'd2:    ar[g] = {{(W-1){1'b0}}, (x_r < a_r)};
        3'd3:    ar[g] = p2 + p3;
        3'd4:    ar[g] = (sm <<< 1) + sm;
        3'd5:    ar[g] = u_r - tr;
        3'd6:    ar[g] = y_r + p4;
        default: ar[g] = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {p1, p2, p3, p4, xn, sm, tr, un, yn} <= '0;
      cf <= 1'b0;
    end else if (run) begin
      for (int k = 0; k < NMUL; k++)
        case (mop[k])
          3'd1: p1 <= mr[k];
          3'd2: p2 <= mr[k];
          3'd3: p3 <= mr[k];
          3'd4: p4 <= mr[k];
          default: ;
        endcase
      for (int k = 0; k < NALU; k++)
        case (aop[k])
          3'd1: xn <= ar[k];
          3'd2: cf <= ar[k][0];
          3'd3: sm <= ar[k];
          3'd4: tr <= ar[k];
          3'd5: un <= ar[k];
          3'd6: yn <= ar[k];
          default: ;
        endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; step <= '0;
      {x_r, y_r, u_r, dx_r, a_r} <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          x_r <= x_in; y_r <= y_in; u_r <= u_in; dx_r <= dx_in; a_r <= a_in;
          busy <= 1'b1; step <= '0;
        end
      end else if (step == SW'(CSTEP)) begin
        x_r <= xn; u_r <= un; y_r <= yn;
        step <= '0;
        if (!cf) begin busy <= 1'b0; done <= 1'b1; end
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  assign y_out = y_r;

  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && x_r == $past(x_in) && y_r == $past(y_in)));
  assert_xstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == SW'(CSTEP)) |=> (x_r == $past(x_r) + $past(dx_r)));
  assert_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(y_out));
  assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && step != SW'(CSTEP)) |=> (busy && step == $past(step) + 1'b1));
  assert_step_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step <= SW'(CSTEP)));
endmodule

// File: tb/sim_euler_diffeq_dp.sv
`timescale 1ns/1ps
module sim_euler_diffeq_dp;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic signed [31:0] xi = '0, yi = '0, ui = '0, dxi = '0, ai = '0;
  logic bz [4];
  logic dn [4];
  logic signed [31:0] yw [4];
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int per [4] = '{8, 7, 7, 6};

  always #10 clk = ~clk;

  euler_diffeq_dp #(.NMUL(1), .NALU(1)) u0 (.clk(clk), .rst_n(rst_n), .start(start), .x_in(xi), .y_in(yi),
    .u_in(ui), .dx_in(dxi), .a_in(ai), .busy(bz[0]), .done(dn[0]), .y_out(yw[0]));
  euler_diffeq_dp #(.NMUL(1), .NALU(2)) u1 (.clk(clk), .rst_n(rst_n), .start(start), .x_in(xi), .y_in(yi),
    .u_in(ui), .dx_in(dxi), .a_in(ai), .busy(bz[1]), .done(dn[1]), .y_out(yw[1]));
  euler_diffeq_dp #(.NMUL(2), .NALU(1)) u2 (.clk(clk), .rst_n(rst_n), .start(start), .x_in(xi), .y_in(yi),
    .u_in(ui), .dx_in(dxi), .a_in(ai), .busy(bz[2]), .done(dn[2]), .y_out(yw[2]));
  euler_diffeq_dp #(.NMUL(2), .NALU(2)) u3 (.clk(clk), .rst_n(rst_n), .start(start), .x_in(xi), .y_in(yi),
    .u_in(ui), .dx_in(dxi), .a_in(ai), .busy(bz[3]), .done(dn[3]), .y_out(yw[3]));

  task automatic chk(input bit ok, input string req, input int inst, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s inst u%0d: actual %0d expected %0d", req, inst, act, exp);
    end
  endtask

  function automatic int qmul(input int p, input int q);
    longint r;
    r = longint'(p) * longint'(q);
    return int'(r >>> 16);
  endfunction

  function automatic void model(input int x, input int y, input int u, input int dx, input int a,
                                output int n, output int yf);
    bit go;
    int xs, us, ys;
    n = 0;
    do begin
      go = (x < a);
      xs = x + dx;
      us = u - 3 * (qmul(qmul(x, u), dx) + qmul(y, dx));
      ys = y + qmul(u, dx);
      x = xs; u = us; y = ys;
      n++;
    end while (go && n < 1000);
    yf = y;
  endfunction

  task automatic run_case(input int x, input int y, input int u, input int dx, input int a, input bit poke);
    int n, yexp;
    model(x, y, u, dx, a, n, yexp);
    @(negedge clk);
    xi = x; yi = y; ui = u; dxi = dx; ai = a; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j <= n * 8 + 2; j++) begin
      for (int i = 0; i < 4; i++) begin
        bit ed, eb;
        ed = (j == n * per[i]);
        eb = (j < n * per[i]);
        if (j == 0) chk(bz[i] == 1'b1, "R1", i, bz[i], 1);
        chk(dn[i] == ed, poke ? "R7 R8" : "R2 R5 R8", i, dn[i], ed);
        chk(bz[i] == eb, "R5 R8", i, bz[i], eb);
        if (ed) chk(yw[i] == yexp, poke ? "R7 R4" : "R3 R4", i, yw[i], yexp);
      end
      if (poke && j == 2) begin
        xi = 32'sh7000_0000; yi = -32'sh1234; ui = 32'sh55; dxi = 32'sh1; ai = -32'sh8000_0000;
        start = 1'b1;
      end else start = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      chk(yw[i] == yexp, "R6", i, yw[i], yexp);
      chk(dn[i] == 1'b0, "R6", i, dn[i], 0);
    end
  endtask

  initial begin
    #(20 * 50000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      chk(bz[i] == 1'b0, "R9", i, bz[i], 0);
      chk(dn[i] == 1'b0, "R9", i, dn[i], 0);
      chk(yw[i] == 0, "R9", i, yw[i], 0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_case(32'sh0, 32'sh10000, 32'sh8000, 32'sh10000, 32'sh30000, 1'b0);
    run_case(32'sh50000, 32'sh2000, -32'sh10000, 32'sh4000, 32'sh10000, 1'b0);
    run_case(-32'sh20000, -32'shC000, 32'sh20000, 32'sh4000, -32'sh10000, 1'b1);
    run_case(32'sh18000, 32'sh7000, 32'sh3000, 32'sh100, 32'sh18000, 1'b0);
    run_case(32'sh0, 32'sh30000, -32'sh28000, 32'sh2000, 32'sh8000, 1'b0);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 4; i++) chk(bz[i] == 1'b0 && dn[i] == 1'b0, "R6", i, bz[i], 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule